// File: doc/BRIEF.md
# Reference-Offset Bitslip Word Aligner

This block sits behind a deserializer and turns a raw stream of parallel words into correctly framed words. The raw words are cut at an arbitrary bit boundary, and that boundary can change after every power-up, reset or clock loss. The transmitter sends a distinctive alignment word (10 bits by default) at a fixed word period. The aligner scans every bit position of a two-word window for that word. It records the offset where the word was found and then shifts its input by single-bit slips until the word appears at a programmed reference offset.

The slip amount is taken from the distance to a fixed reference, not from the first boundary seen. As a result the slip setting, and with it the receive latency, comes out the same on every restart with the same line phase. Lock is claimed only after the alignment word has been seen repeatedly at the reference offset. Lock is given up after a run of missing or misplaced alignment words. Each loss of lock is counted.

Top module: `word_aligner`

## Requirements
- R1: During and directly after a synchronous reset, `locked` is 0, `loss_count` is 0 and `meas_offset` is 0.
- R2: The alignment word (default 10'b0011111010) is searched at all W offsets of the window formed by the newer slipped word above the older one. Offset k means window bits k..k+W-1, and a lower bit index is earlier on the line. `meas_offset` holds the offset of the most recent detection.
- R3: When a detection is at offset m and the reference is r, the aligner applies (m - r) mod W single-bit slips. After that, `aligned_word` carries the transmitted words intact, one every clock, with bit j of the output equal to bit j of the transmitted word.
- R4: `locked` never rises while the alignment word is absent from the stream.
- R5: `locked` rises on the third consecutive detection at the reference offset. On the cycle it rises, `aligned_word` shows the alignment word and `meas_offset` equals `ref_offset`.
- R6: With the same line phase and the same reference, the latency from transmitted word to `aligned_word` is identical after every reset and after every relock that follows a loss of lock.
- R7: While locked, an alignment word is expected every PERIOD words (default 8). Up to three consecutive expected words may be missing without `locked` falling.
- R8: The fourth consecutive missing expected word clears `locked` and increments `loss_count` at the same edge. The search then restarts and locks again once alignment words return.
- R9: An alignment word that arrives at a different offset, for example after a phase jump on the line, counts as missing. Lock is lost as in R8 and then regained at the reference offset.
- R10: `loss_count` changes only on the cycle in which `locked` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_word | input | W (10) | Raw parallel word from the deserializer, bit 0 earliest |
| ref_offset | input | clog2(W) (4) | Programmed reference offset, must be below W |
| aligned_word | output | W (10) | Framed output word |
| locked | output | 1 | Alignment established and being tracked |
| meas_offset | output | clog2(W) (4) | Offset of the most recent alignment word detection |
| loss_count | output | LOSS_W (8) | Number of lock losses since reset, saturating |

## Verification
The stimulus is a bit stream built from transmitted words and presented to the aligner at a chosen line phase. Phases that need a nonzero slip are used alongside a phase that needs none, which separates the slip arithmetic from the plain detect-and-confirm path, and two reference values are tried. Alignment words are suppressed for three periods and for six periods: the first run must keep lock and the second must drop it exactly at the fourth expected slot. A mid-run phase jump creates misplaced words, which tells misplacement handling apart from the plain missing-word handling. Repeated resets at one phase compare latencies, and a stream with no alignment word at all must never produce lock.

// File: rtl/wa_pkg.sv
`timescale 1ns/1ps
package wa_pkg;

  typedef enum logic [2:0] {
    ST_HUNT    = 3'd0,
    ST_SLIP    = 3'd1,
    ST_SETTLE  = 3'd2,
    ST_CONFIRM = 3'd3,
    ST_TRACK   = 3'd4
  } wa_state_e;

endpackage

// File: rtl/wa_slipper.sv
`timescale 1ns/1ps
// Bit-granular shifter: selects W bits out of the last two raw words.
module wa_slipper #(
  parameter int W    = 10,
  parameter int OFFW = $clog2(W)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [W-1:0]    rx_word,
  input  logic [OFFW-1:0] slip_pos,
  output logic [W-1:0]    sh_word,
  output logic [W-1:0]    sh_prev
);

  logic [W-1:0]   raw_prev;
  logic [2*W-1:0] raw_pair;

  always_comb raw_pair = {rx_word, raw_prev};

  always_ff @(posedge clk) begin
    if (rst) begin
      raw_prev <= '0;
      sh_word  <= '0;
      sh_prev  <= '0;
    end else begin
      raw_prev <= rx_word;
      sh_word  <= raw_pair[slip_pos +: W];
      sh_prev  <= sh_word;
    end
  end

endmodule

// File: rtl/wa_scanner.sv
`timescale 1ns/1ps
// Compares the alignment pattern against every offset of the window.
module wa_scanner #(
  parameter int           W          = 10,
  parameter int           OFFW       = $clog2(W),
  parameter logic [W-1:0] ALIGN_WORD = 10'b0011111010
) (
  input  logic [2*W-1:0]  window,
  input  logic [OFFW-1:0] ref_offset,
  output logic            hit,
  output logic [OFFW-1:0] hit_offset,
  output logic            ref_hit
);

  logic [W-1:0] match;

  for (genvar k = 0; k < W; k++) begin : g_cmp
    assign match[k] = (window[k +: W] == ALIGN_WORD);
  end

  always_comb begin
    hit_offset = '0;
    for (int k = W - 1; k >= 0; k--) begin
      if (match[k]) hit_offset = OFFW'(k);
    end
  end

  assign hit     = |match;
  assign ref_hit = match[ref_offset];

endmodule

// File: rtl/wa_fsm.sv
`timescale 1ns/1ps
// Search, slip, confirm and track sequencing.
module wa_fsm
  import wa_pkg::*;
#(
  parameter int W          = 10,
  parameter int OFFW       = $clog2(W),
  parameter int PERIOD     = 8,
  parameter int LOCK_HITS  = 3,
  parameter int MISS_LIMIT = 4,
  parameter int SETTLE     = 2,
  parameter int LOSS_W     = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hit,
  input  logic [OFFW-1:0]   hit_offset,
  input  logic              ref_hit,
  input  logic [OFFW-1:0]   ref_offset,
  output logic [OFFW-1:0]   slip_pos,
  output logic              locked,
  output logic [OFFW-1:0]   meas_offset,
  output logic [LOSS_W-1:0] loss_count
);

  localparam int HIT_W  = $clog2(LOCK_HITS + 1);
  localparam int MISS_W = $clog2(MISS_LIMIT + 1);
  localparam int PER_W  = $clog2(PERIOD);
  localparam int SET_W  = $clog2(SETTLE + 1);
  localparam logic [OFFW:0] W_EXT = (OFFW + 1)'(W);

  wa_state_e         state;
  logic [OFFW-1:0]   slip_left;
  logic [HIT_W-1:0]  hits;
  logic [MISS_W-1:0] misses;
  logic [PER_W-1:0]  frame_pos;
  logic [SET_W-1:0]  settle_cnt;
  logic [OFFW:0]     dist_sum;
  logic [OFFW-1:0]   slip_need;
  logic              window_valid;

  // slips needed = (measured - reference) mod W
  always_comb begin
    dist_sum  = {1'b0, hit_offset} + W_EXT - {1'b0, ref_offset};
    slip_need = (dist_sum >= W_EXT) ? OFFW'(dist_sum - W_EXT) : OFFW'(dist_sum);
  end

  assign window_valid = (state != ST_SLIP) && (state != ST_SETTLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_HUNT;
      slip_pos    <= '0;
      slip_left   <= '0;
      hits        <= '0;
      misses      <= '0;
      frame_pos   <= '0;
      settle_cnt  <= '0;
      locked      <= 1'b0;
      meas_offset <= '0;
      loss_count  <= '0;
    end else begin
      if (hit && window_valid) meas_offset <= hit_offset;

      unique case (state)
        ST_HUNT: begin
          if (hit) begin
            if (hit_offset == ref_offset) begin
              hits  <= HIT_W'(1);
              state <= ST_CONFIRM;
            end else begin
              slip_left <= slip_need;
              state     <= ST_SLIP;
            end
          end
        end

        ST_SLIP: begin
          slip_pos  <= (slip_pos == OFFW'(W - 1)) ? '0 : slip_pos + 1'b1;
          slip_left <= slip_left - 1'b1;
          if (slip_left == OFFW'(1)) begin
            settle_cnt <= SET_W'(SETTLE - 1);
            state      <= ST_SETTLE;
          end
        end

        ST_SETTLE: begin
          if (settle_cnt == '0) begin
            hits  <= '0;
            state <= ST_CONFIRM;
          end else begin
            settle_cnt <= settle_cnt - 1'b1;
          end
        end

        ST_CONFIRM: begin
          if (hit) begin
            if (hit_offset == ref_offset) begin
              if (hits == HIT_W'(LOCK_HITS - 1)) begin
                locked    <= 1'b1;
                misses    <= '0;
                frame_pos <= PER_W'(1);
                state     <= ST_TRACK;
              end else begin
                hits <= hits + 1'b1;
              end
            end else begin
              slip_left <= slip_need;
              state     <= ST_SLIP;
            end
          end
        end

        ST_TRACK: begin
          frame_pos <= (frame_pos == PER_W'(PERIOD - 1)) ? '0 : frame_pos + 1'b1;
          if (frame_pos == '0) begin
            if (ref_hit) begin
              misses <= '0;
            end else if (misses == MISS_W'(MISS_LIMIT - 1)) begin
              locked <= 1'b0;
              misses <= '0;
              if (~&loss_count) loss_count <= loss_count + 1'b1;
              state  <= ST_HUNT;
            end else begin
              misses <= misses + 1'b1;
            end
          end
        end

        default: state <= ST_HUNT;
      endcase
    end
  end

endmodule

// File: rtl/word_aligner.sv
`timescale 1ns/1ps
module word_aligner #(
  parameter int           W          = 10,
  parameter int           OFFW       = $clog2(W),
  parameter logic [W-1:0] ALIGN_WORD = 10'b0011111010,
  parameter int           PERIOD     = 8,
  parameter int           LOCK_HITS  = 3,
  parameter int           MISS_LIMIT = 4,
  parameter int           SETTLE     = 2,
  parameter int           LOSS_W     = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [W-1:0]      rx_word,
  input  logic [OFFW-1:0]   ref_offset,
  output logic [W-1:0]      aligned_word,
  output logic              locked,
  output logic [OFFW-1:0]   meas_offset,
  output logic [LOSS_W-1:0] loss_count
);

  logic [OFFW-1:0] slip_pos;
  logic [W-1:0]    sh_word;
  logic [W-1:0]    sh_prev;
  logic [2*W-1:0]  window;
  logic            hit;
  logic [OFFW-1:0] hit_offset;
  logic            ref_hit;

  wa_slipper #(.W(W), .OFFW(OFFW)) u_slipper (
    .clk      (clk),
    .rst      (rst),
    .rx_word  (rx_word),
    .slip_pos (slip_pos),
    .sh_word  (sh_word),
    .sh_prev  (sh_prev)
  );

  assign window = {sh_word, sh_prev};

  wa_scanner #(.W(W), .OFFW(OFFW), .ALIGN_WORD(ALIGN_WORD)) u_scanner (
    .window     (window),
    .ref_offset (ref_offset),
    .hit        (hit),
    .hit_offset (hit_offset),
    .ref_hit    (ref_hit)
  );

  wa_fsm #(
    .W(W), .OFFW(OFFW), .PERIOD(PERIOD), .LOCK_HITS(LOCK_HITS),
    .MISS_LIMIT(MISS_LIMIT), .SETTLE(SETTLE), .LOSS_W(LOSS_W)
  ) u_fsm (
    .clk         (clk),
    .rst         (rst),
    .hit         (hit),
    .hit_offset  (hit_offset),
    .ref_hit     (ref_hit),
    .ref_offset  (ref_offset),
    .slip_pos    (slip_pos),
    .locked      (locked),
    .meas_offset (meas_offset),
    .loss_count  (loss_count)
  );

  always_ff @(posedge clk) begin
    if (rst) aligned_word <= '0;
    else     aligned_word <= window[ref_offset +: W];
  end

endmodule

// File: rtl/word_aligner_checker.sv
`timescale 1ns/1ps
module word_aligner_checker #(
  parameter int           W          = 10,
  parameter int           OFFW       = $clog2(W),
  parameter logic [W-1:0] ALIGN_WORD = 10'b0011111010,
  parameter int           LOSS_W     = 8
) (
  input logic              clk,
  input logic              rst,
  input logic [OFFW-1:0]   ref_offset,
  input logic [W-1:0]      aligned_word,
  input logic              locked,
  input logic [OFFW-1:0]   meas_offset,
  input logic [LOSS_W-1:0] loss_count
);

  AST_RESET_CLEAN: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!locked && loss_count == '0 && meas_offset == '0)); // R1

  AST_OFFSET_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    (32'(meas_offset) < W)); // R2

  AST_LOCK_ON_WORD: assert property (@(posedge clk) disable iff (rst)
    $rose(locked) |-> (aligned_word == ALIGN_WORD && meas_offset == ref_offset)); // R5

  AST_LOSS_ON_DROP: assert property (@(posedge clk) disable iff (rst)
    $fell(locked) |-> (loss_count == $past(loss_count) + 1'b1 || &$past(loss_count))); // R8

  AST_LOSS_STABLE: assert property (@(posedge clk) disable iff (rst)
    !$fell(locked) |-> $stable(loss_count)); // R10

endmodule

bind word_aligner word_aligner_checker #(
  .W(W), .OFFW(OFFW), .ALIGN_WORD(ALIGN_WORD), .LOSS_W(LOSS_W)
) u_checker (
  .clk          (clk),
  .rst          (rst),
  .ref_offset   (ref_offset),
  .aligned_word (aligned_word),
  .locked       (locked),
  .meas_offset  (meas_offset),
  .loss_count   (loss_count)
);

// File: tb/test_word_aligner.sv
`timescale 1ns/1ps
module test_word_aligner;

  localparam int W      = 10;
  localparam int PERIOD = 8;
  localparam logic [W-1:0] COMMA = 10'b0011111010;
  localparam logic [W-1:0] PAY_MASK = 10'h1B6;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [9:0] rx_word = '0;
  logic [3:0] ref_offset = 4'd5;
  logic [9:0] aligned_word;
  logic       locked;
  logic [3:0] meas_offset;
  logic [7:0] loss_count;

  always #2 clk = ~clk;

  word_aligner i_word_aligner (
    .clk          (clk),
    .rst          (rst),
    .rx_word      (rx_word),
    .ref_offset   (ref_offset),
    .aligned_word (aligned_word),
    .locked       (locked),
    .meas_offset  (meas_offset),
    .loss_count   (loss_count)
  );

  int vectors = 0;
  int errors  = 0;
  int cyc     = 0;
  int line_phase = 3;
  bit comma_on = 1'b1;
  int kill_lo = -1;
  int kill_hi = -1;

  int   lat_now = -1;
  bit   cont_on = 1'b0;
  int   commas_seen = 0;
  int   fall_cyc = -1;
  logic prev_locked = 1'b0;
  logic [7:0] prev_loss = '0;

  function automatic logic [9:0] tx_word(int n);
    if (n < 0) return '0;
    if (comma_on && (n % PERIOD == 0) && !(n >= kill_lo && n < kill_hi)) return COMMA;
    return 10'(n) & PAY_MASK;
  endfunction

  function automatic logic [9:0] rx_calc(int t);
    logic [9:0] w;
    for (int j = 0; j < W; j++) begin
      int idx;
      logic [9:0] src;
      idx  = W * t + line_phase + j;
      src  = tx_word(idx / W);
      w[j] = src[idx % W];
    end
    return w;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s at cycle %0d: actual %0d expected %0d", req, cyc, act, exp);
    end
  endtask

  // one clock: drive after the edge, sample and compare at the falling edge
  task automatic step();
    bit rise;
    @(posedge clk);
    #1;
    cyc++;
    rx_word = rx_calc(cyc);
    @(negedge clk);
    if (!rst) begin
      if (aligned_word == COMMA) commas_seen++;
      rise = locked && !prev_locked;
      if (rise) begin
        chk(aligned_word == COMMA, "R5 word at lock", int'(aligned_word), int'(COMMA));
        chk(meas_offset == ref_offset, "R5 offset at lock", int'(meas_offset), int'(ref_offset));
        chk(commas_seen >= 3, "R5 three sightings", commas_seen, 3);
        lat_now = -1;
        for (int d = 2; d <= 4; d++) if (tx_word(cyc - d) == COMMA) lat_now = d;
        chk(lat_now != -1, "R3 boundary found", lat_now, 3);
        cont_on = 1'b1;
      end
      if (!locked && prev_locked) begin
        chk(loss_count == prev_loss + 8'd1, "R8 loss increment", int'(loss_count), int'(prev_loss) + 1);
        cont_on = 1'b0;
        commas_seen = 0;
        fall_cyc = cyc;
      end else begin
        chk(loss_count == prev_loss, "R10 loss stable", int'(loss_count), int'(prev_loss));
      end
      if (locked && cont_on && lat_now > 0)
        chk(aligned_word == tx_word(cyc - lat_now), "R3 framed data",
            int'(aligned_word), int'(tx_word(cyc - lat_now)));
      prev_locked = locked;
      prev_loss   = loss_count;
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (4) step();
    chk(locked == 1'b0, "R1 locked", int'(locked), 0);
    chk(loss_count == 8'd0, "R1 loss", int'(loss_count), 0);
    chk(meas_offset == 4'd0, "R1 offset", int'(meas_offset), 0);
    rst = 1'b0;
    prev_locked = 1'b0;
    prev_loss   = '0;
    commas_seen = 0;
    cont_on     = 1'b0;
    lat_now     = -1;
  endtask

  // waits for lock, recording the first measured offset seen after reset
  task automatic wait_lock(int limit, output int first_meas);
    first_meas = 0;
    for (int i = 0; i < limit && !locked; i++) begin
      step();
      if (first_meas == 0 && meas_offset != 4'd0) first_meas = int'(meas_offset);
    end
    chk(locked == 1'b1, "R5 lock reached", int'(locked), 1);
  endtask

  task automatic wait_unlock(int limit);
    for (int i = 0; i < limit && locked; i++) step();
    chk(locked == 1'b0, "R8 lock dropped", int'(locked), 0);
  endtask

  initial begin
    int first_meas;
    int lat_ref;
    bit stayed;

    // T1: phase 3, reference 5 -> first detection at offset 7, then slips (R2, R3)
    line_phase = 3; ref_offset = 4'd5;
    do_reset();
    wait_lock(300, first_meas);
    chk(first_meas == 7, "R2 measured offset", first_meas, 7);
    lat_ref = lat_now;
    repeat (100) step();

    // T2: three missing words keep lock (R7)
    kill_lo = ((cyc / PERIOD) + 2) * PERIOD;
    kill_hi = kill_lo + 3 * PERIOD;
    stayed = 1'b1;
    repeat (60) begin step(); if (!locked) stayed = 1'b0; end
    chk(stayed, "R7 lock kept over three misses", int'(stayed), 1);
    chk(loss_count == 8'd0, "R7 no loss counted", int'(loss_count), 0);

    // T3: six missing words drop lock at the fourth expected slot (R8), relock (R6)
    kill_lo = ((cyc / PERIOD) + 2) * PERIOD;
    kill_hi = kill_lo + 6 * PERIOD;
    wait_unlock(200);
    chk(fall_cyc - lat_ref == kill_lo + 3 * PERIOD, "R8 fourth slot",
        fall_cyc - lat_ref, kill_lo + 3 * PERIOD);
    chk(loss_count == 8'd1, "R8 loss count", int'(loss_count), 1);
    wait_lock(300, first_meas);
    chk(lat_now == lat_ref, "R6 latency after relock", lat_now, lat_ref);
    repeat (40) step();

    // T4: phase jump gives misplaced words (R9)
    line_phase = 8; cont_on = 1'b0;
    wait_unlock(200);
    chk(loss_count == 8'd2, "R9 loss count", int'(loss_count), 2);
    wait_lock(300, first_meas);
    chk(meas_offset == ref_offset, "R9 relocked at reference", int'(meas_offset), int'(ref_offset));
    repeat (40) step();

    // T5: other reference, phase 8 -> first detection at offset 2 (R2)
    ref_offset = 4'd0;
    do_reset();
    wait_lock(300, first_meas);
    chk(first_meas == 2, "R2 measured offset ref0", first_meas, 2);
    repeat (40) step();

    // T6: same phase and reference as T1 after reset gives the same latency (R6)
    line_phase = 3; ref_offset = 4'd5;
    do_reset();
    wait_lock(300, first_meas);
    chk(lat_now == lat_ref, "R6 latency after reset", lat_now, lat_ref);
    repeat (40) step();

    // T7: no alignment word at all, never locks (R4)
    comma_on = 1'b0;
    do_reset();
    stayed = 1'b1;
    repeat (150) begin step(); if (locked) stayed = 1'b0; end
    chk(stayed, "R4 no lock without word", int'(!stayed), 0);

    // T8: phase needing no slip: detection already at the reference (R3)
    comma_on = 1'b1; line_phase = 5; ref_offset = 4'd5;
    do_reset();
    wait_lock(300, first_meas);
    chk(first_meas == 5, "R3 zero-slip offset", first_meas, 5);
    repeat (40) step();

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog at cycle %0d: actual running expected finished", cyc);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

endmodule